// File: doc/BRIEF.md
# Cache performance counter bank

This block counts activity of a shared cache for profiling software. It holds a parameterised number (one to eight) of 32-bit event counters and one free-running 64-bit cycle counter. Each event counter is steered to one of eight event groups by its type register. Each cycle it adds one when counting is switched on globally, its own enable bit is set and the pulse of its selected group is high.

Software reaches the bank through a register file addressed by word index. It has one write port and a separate combinational read port, both 64 bits wide. Counter enable, interrupt enable and overflow status each have a set address and a clear address. These take a bitmask in which bit n selects event counter n and bit 31 always selects the cycle counter. A counter that wraps raises its overflow flag. The interrupt line is high while any flagged counter has its interrupt enabled. Software reads the flags and writes the same bits to the clear address to acknowledge them.

Top module: `cache_perf_bank`

## Requirements
- R1: After reset every counter, enable, flag and stored register reads zero, `irq` is low, and index 0x400 reads only the counter-count field.
- R2: At index 0x400, written bit 0 is the global count enable and reads back in bit 0. Bits 15:11 always read the number of event counters. With the global enable clear no counter moves.
- R3: A write to 0x400 with bit 1 set zeroes every event counter, and with bit 2 set zeroes the cycle counter (0x6 zeroes both). The zeroing wins over an increment in the same cycle.
- R4: The pairs clear/set are 0x403/0x404 for counter enable, 0x405/0x406 for interrupt enable and 0x407/0x408 for overflow. Only bits written as 1 change. Both addresses of a pair read the current mask. Only bits 0..N-1 and bit 31 exist; other bits read zero.
- R5: Event counter n adds exactly one in a cycle when the global enable is set, enable bit n is set and `evt_pulse[type n]` is high. Otherwise it holds. Its type sits in bits 2:0 of index 0x424 + 0x10·n.
- R6: The 64-bit cycle counter at 0x40A adds one every cycle in which the global enable and enable bit 31 are set.
- R7: Writing a count (0x421 + 0x10·n, or 0x40A) loads the written value and takes precedence over an increment in that cycle.
- R8: An event counter stepping from 0xFFFFFFFF returns to zero and sets overflow bit n on the following cycle. The cycle counter does the same from all ones and sets bit 31.
- R9: A wrap in the same cycle as a software clear of that overflow bit leaves the flag set.
- R10: `irq` is high exactly while some overflow flag has its interrupt-enable bit set.
- R11: Counter control (0x420 + 0x10·n), filter (0x423 + 0x10·n) and cycle control (0x409) store 32 bits, read back, and do not affect counting.
- R12: Reads of unmapped indices return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write word index |
| wr_data | input | 64 | Write data |
| rd_addr | input | 12 | Read word index |
| rd_data | output | 64 | Read data for `rd_addr`, same cycle |
| evt_pulse | input | 2**GRP_W | One pulse line per event group |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach is an overflow that coincides with something else. Examples are a wrap in the very cycle software clears that flag, a wrap on the 64-bit counter, or a zeroing write landing on an active increment. None of these arises from plain counting in a short run. The stimulus first preloads counts to a few steps below all ones through the value registers. It then lines up the event pulse, the clear write and the wrap on one chosen cycle, and reads the flags back through the overflow register and the interrupt pin. A long random phase then mixes writes to every mapped index with random pulses, while the bench's own model is compared on every clock.

// File: rtl/cpb_pkg.sv
`timescale 1ns/1ps
package cpb_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 64;
  localparam int MASK_W  = 32;
  localparam int CYC_BIT = 31;
  localparam int CNT_LSB = 11;
  localparam int CNT_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 12'h403;
  localparam logic [ADDR_W-1:0] A_CEN_SET = 12'h404;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 12'h405;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 12'h406;
  localparam logic [ADDR_W-1:0] A_OVF_CLR = 12'h407;
  localparam logic [ADDR_W-1:0] A_OVF_SET = 12'h408;
  localparam logic [ADDR_W-1:0] A_CYC_CTL = 12'h409;
  localparam logic [ADDR_W-1:0] A_CYC_VAL = 12'h40A;
  localparam logic [ADDR_W-1:0] A_PC_CTL  = 12'h420;
  localparam logic [ADDR_W-1:0] A_PC_VAL  = 12'h421;
  localparam logic [ADDR_W-1:0] A_PC_FLT  = 12'h423;
  localparam logic [ADDR_W-1:0] A_PC_TYP  = 12'h424;
  localparam int                PC_STRIDE = 16;

  // Index of a per-counter register for counter n.
  function automatic logic [ADDR_W-1:0] pc_addr(input logic [ADDR_W-1:0] base, input int n);
    return base + ADDR_W'(n * PC_STRIDE);
  endfunction

  // Bits that exist in every set/clear mask.
  function automatic logic [MASK_W-1:0] impl_mask(input int n_evt);
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < CYC_BIT; i++) if (i < n_evt) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  // Increment with carry out; the carry marks a wrap.
  function automatic logic [32:0] bump32(input logic [31:0] v);
    return {1'b0, v} + 33'd1;
  endfunction

  function automatic logic [64:0] bump64(input logic [63:0] v);
    return {1'b0, v} + 65'd1;
  endfunction
endpackage

// File: rtl/cpb_mask_reg.sv
`timescale 1ns/1ps
module cpb_mask_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] kept, nxt;

  always_comb begin
    kept = clr_we ? (q & ~bits) : q;
    // hardware set is applied after the clear so it is never lost
    nxt  = (kept | (set_we ? bits : '0) | hw_set) & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/cpb_evt_ctr.sv
`timescale 1ns/1ps
module cpb_evt_ctr
  import cpb_pkg::*;
#(
  parameter int GRP_W = 3,
  localparam int NUM_GRP = 1 << GRP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_GRP-1:0] evt_pulse,
  input  logic               zero,
  input  logic               we_ctl,
  input  logic               we_val,
  input  logic               we_flt,
  input  logic               we_typ,
  input  logic [31:0]        wdata,
  output logic [31:0]        val_q,
  output logic [31:0]        ctl_q,
  output logic [31:0]        flt_q,
  output logic [GRP_W-1:0]   typ_q,
  output logic               wrap
);
  logic        inc;
  logic [32:0] stepped;

  assign inc     = run & evt_pulse[typ_q];
  assign stepped = bump32(val_q);
  assign wrap    = inc & stepped[32] & ~zero & ~we_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      ctl_q <= '0;
      flt_q <= '0;
      typ_q <= '0;
    end else begin
      if (zero)        val_q <= '0;
      else if (we_val) val_q <= wdata;
      else if (inc)    val_q <= stepped[31:0];
      if (we_ctl) ctl_q <= wdata;
      if (we_flt) flt_q <= wdata;
      if (we_typ) typ_q <= wdata[GRP_W-1:0];
    end
  end
endmodule

// File: rtl/cpb_cyc_ctr.sv
`timescale 1ns/1ps
module cpb_cyc_ctr
  import cpb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        zero,
  input  logic        we_ctl,
  input  logic        we_val,
  input  logic [63:0] wdata,
  output logic [63:0] val_q,
  output logic [31:0] ctl_q,
  output logic        wrap
);
  logic [64:0] stepped;

  assign stepped = bump64(val_q);
  assign wrap    = run & stepped[64] & ~zero & ~we_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      ctl_q <= '0;
    end else begin
      if (zero)        val_q <= '0;
      else if (we_val) val_q <= wdata;
      else if (run)    val_q <= stepped[63:0];
      if (we_ctl) ctl_q <= wdata[31:0];
    end
  end
endmodule

// File: rtl/cache_perf_bank.sv
`timescale 1ns/1ps
module cache_perf_bank
  import cpb_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int GRP_W   = 3,
  localparam int NUM_GRP = 1 << GRP_W,
  localparam logic [MASK_W-1:0] VALID = impl_mask(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_GRP-1:0] evt_pulse,
  output logic               irq
);
  logic                    glob_en_q;
  logic                    ctl_wr, zero_evt, zero_cyc;
  logic [MASK_W-1:0]       cen_q, ien_q, ovf_q, wrap_vec;
  logic [31:0]             ev_val [NUM_EVT];
  logic [31:0]             ev_ctl [NUM_EVT];
  logic [31:0]             ev_flt [NUM_EVT];
  logic [GRP_W-1:0]        ev_typ [NUM_EVT];
  logic [NUM_EVT-1:0]      ev_wrap;
  logic [NUM_EVT*32-1:0]   evt_val_flat;
  logic [63:0]             cyc_val;
  logic [31:0]             cyc_ctl;
  logic                    cyc_wrap;
  logic                    addr_hit;

  // global control
  assign ctl_wr   = wr_en && (wr_addr == A_CTRL);
  assign zero_evt = ctl_wr & wr_data[1];
  assign zero_cyc = ctl_wr & wr_data[2];

  always_ff @(posedge clk) begin
    if (!rst_n)      glob_en_q <= 1'b0;
    else if (ctl_wr) glob_en_q <= wr_data[0];
  end

  // set/clear mask registers
  cpb_mask_reg #(.W(MASK_W), .VALID(VALID)) u_cen (
    .clk, .rst_n,
    .set_we (wr_en && wr_addr == A_CEN_SET),
    .clr_we (wr_en && wr_addr == A_CEN_CLR),
    .bits   (wr_data[MASK_W-1:0]),
    .hw_set ('0),
    .q      (cen_q)
  );

  cpb_mask_reg #(.W(MASK_W), .VALID(VALID)) u_ien (
    .clk, .rst_n,
    .set_we (wr_en && wr_addr == A_IEN_SET),
    .clr_we (wr_en && wr_addr == A_IEN_CLR),
    .bits   (wr_data[MASK_W-1:0]),
    .hw_set ('0),
    .q      (ien_q)
  );

  cpb_mask_reg #(.W(MASK_W), .VALID(VALID)) u_ovf (
    .clk, .rst_n,
    .set_we (wr_en && wr_addr == A_OVF_SET),
    .clr_we (wr_en && wr_addr == A_OVF_CLR),
    .bits   (wr_data[MASK_W-1:0]),
    .hw_set (wrap_vec),
    .q      (ovf_q)
  );

  // event counters
  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    cpb_evt_ctr #(.GRP_W(GRP_W)) u_ctr (
      .clk, .rst_n,
      .run       (glob_en_q & cen_q[n]),
      .evt_pulse (evt_pulse),
      .zero      (zero_evt),
      .we_ctl    (wr_en && wr_addr == pc_addr(A_PC_CTL, n)),
      .we_val    (wr_en && wr_addr == pc_addr(A_PC_VAL, n)),
      .we_flt    (wr_en && wr_addr == pc_addr(A_PC_FLT, n)),
      .we_typ    (wr_en && wr_addr == pc_addr(A_PC_TYP, n)),
      .wdata     (wr_data[31:0]),
      .val_q     (ev_val[n]),
      .ctl_q     (ev_ctl[n]),
      .flt_q     (ev_flt[n]),
      .typ_q     (ev_typ[n]),
      .wrap      (ev_wrap[n])
    );
    assign evt_val_flat[n*32 +: 32] = ev_val[n];
  end

  // cycle counter
  cpb_cyc_ctr u_cyc (
    .clk, .rst_n,
    .run    (glob_en_q & cen_q[CYC_BIT]),
    .zero   (zero_cyc),
    .we_ctl (wr_en && wr_addr == A_CYC_CTL),
    .we_val (wr_en && wr_addr == A_CYC_VAL),
    .wdata  (wr_data),
    .val_q  (cyc_val),
    .ctl_q  (cyc_ctl),
    .wrap   (cyc_wrap)
  );

  always_comb begin
    wrap_vec                = '0;
    wrap_vec[NUM_EVT-1:0]   = ev_wrap;
    wrap_vec[CYC_BIT]       = cyc_wrap;
  end

  assign irq = |(ovf_q & ien_q);

  // read decode
  always_comb begin
    rd_data  = '0;
    addr_hit = 1'b0;
    case (rd_addr)
      A_CTRL: begin
        addr_hit = 1'b1;
        rd_data[0] = glob_en_q;
        rd_data[CNT_LSB +: CNT_W] = CNT_W'(NUM_EVT);
      end
      A_CEN_CLR, A_CEN_SET: begin addr_hit = 1'b1; rd_data[MASK_W-1:0] = cen_q; end
      A_IEN_CLR, A_IEN_SET: begin addr_hit = 1'b1; rd_data[MASK_W-1:0] = ien_q; end
      A_OVF_CLR, A_OVF_SET: begin addr_hit = 1'b1; rd_data[MASK_W-1:0] = ovf_q; end
      A_CYC_CTL: begin addr_hit = 1'b1; rd_data[31:0] = cyc_ctl; end
      A_CYC_VAL: begin addr_hit = 1'b1; rd_data = cyc_val; end
      default: ;
    endcase
    for (int n = 0; n < NUM_EVT; n++) begin
      if (rd_addr == pc_addr(A_PC_CTL, n)) begin addr_hit = 1'b1; rd_data[31:0] = ev_ctl[n]; end
      if (rd_addr == pc_addr(A_PC_VAL, n)) begin addr_hit = 1'b1; rd_data[31:0] = ev_val[n]; end
      if (rd_addr == pc_addr(A_PC_FLT, n)) begin addr_hit = 1'b1; rd_data[31:0] = ev_flt[n]; end
      if (rd_addr == pc_addr(A_PC_TYP, n)) begin addr_hit = 1'b1; rd_data[GRP_W-1:0] = ev_typ[n]; end
    end
  end
endmodule

// File: rtl/cpb_checker.sv
`timescale 1ns/1ps
module cpb_checker
  import cpb_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic                  wr_zero_bit,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  irq,
  input logic                  addr_hit,
  input logic                  glob_en_q,
  input logic [MASK_W-1:0]     ovf_q,
  input logic [MASK_W-1:0]     wrap_vec,
  input logic [NUM_EVT*32-1:0] evt_val_flat,
  input logic [63:0]           cyc_val
);
  // R8 and R9: a wrap always leaves its flag set, even under a clear
  p_wrap_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en_q && !wr_en) |=> ($stable(evt_val_flat) && $stable(cyc_val)));

  p_zero_on_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_zero_bit) |=> (evt_val_flat == '0));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap_vec) != '0 || $past(wr_en)));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (rd_data == '0));

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_step
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (evt_val_flat[n*32 +: 32] == $past(evt_val_flat[n*32 +: 32]) ||
                  evt_val_flat[n*32 +: 32] == $past(evt_val_flat[n*32 +: 32]) + 32'd1));
  end
endmodule

bind cache_perf_bank cpb_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_zero_bit  (wr_data[1]),
  .rd_data      (rd_data),
  .irq          (irq),
  .addr_hit     (addr_hit),
  .glob_en_q    (glob_en_q),
  .ovf_q        (ovf_q),
  .wrap_vec     (wrap_vec),
  .evt_val_flat (evt_val_flat),
  .cyc_val      (cyc_val)
);

// File: tb/tb_cache_perf_bank.sv
`timescale 1ns/1ps
module tb_cache_perf_bank;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [7:0]  evt_pulse = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  cache_perf_bank #(.NUM_EVT(NE), .GRP_W(3)) dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .evt_pulse, .irq
  );

  // behavioural reference model
  logic [31:0] m_ev [NE];
  logic [31:0] m_ctl [NE];
  logic [31:0] m_flt [NE];
  logic [2:0]  m_typ [NE];
  logic [63:0] m_cyc;
  logic [31:0] m_cycctl, m_cen, m_ien, m_ovf, m_valid;
  bit          m_gen;

  int    vectors = 0;
  int    miscompares = 0;
  int    rp = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic logic [11:0] sweep_addr(input int i);
    int k;
    k = i % 45;
    case (k)
      0: return 12'h400;  1: return 12'h403;  2: return 12'h404;
      3: return 12'h405;  4: return 12'h406;  5: return 12'h407;
      6: return 12'h408;  7: return 12'h409;  8: return 12'h40A;
      41: return 12'h401; 42: return 12'h422; 43: return 12'h4A1;
      44: return 12'h000;
      default: begin
        int c, o;
        c = (k - 9) / 4;
        o = (k - 9) % 4;
        return 12'(32'h420 + c * 16 + (o == 0 ? 0 : o == 1 ? 1 : o == 2 ? 3 : 4));
      end
    endcase
  endfunction

  function automatic logic [63:0] model_read(input logic [11:0] a);
    logic [63:0] r;
    r = '0;
    if (a == 12'h400) r = {48'd0, 5'(NE), 10'd0, m_gen};
    else if (a == 12'h403 || a == 12'h404) r = {32'd0, m_cen};
    else if (a == 12'h405 || a == 12'h406) r = {32'd0, m_ien};
    else if (a == 12'h407 || a == 12'h408) r = {32'd0, m_ovf};
    else if (a == 12'h409) r = {32'd0, m_cycctl};
    else if (a == 12'h40A) r = m_cyc;
    for (int n = 0; n < NE; n++) begin
      if (a == 12'(32'h420 + n * 16)) r = {32'd0, m_ctl[n]};
      if (a == 12'(32'h421 + n * 16)) r = {32'd0, m_ev[n]};
      if (a == 12'(32'h423 + n * 16)) r = {32'd0, m_flt[n]};
      if (a == 12'(32'h424 + n * 16)) r = {61'd0, m_typ[n]};
    end
    return r;
  endfunction

  task automatic model_update(input bit we, input logic [11:0] wa, input logic [63:0] wd,
                              input logic [7:0] ev);
    logic [31:0] hw, sel;
    bit ze, zc, inc;
    hw = '0;
    ze = we && wa == 12'h400 && wd[1];
    zc = we && wa == 12'h400 && wd[2];
    for (int n = 0; n < NE; n++) begin
      inc = m_gen && m_cen[n] && ev[m_typ[n]];
      if (ze) m_ev[n] = 0;
      else if (we && wa == 12'(32'h421 + n * 16)) m_ev[n] = wd[31:0];
      else if (inc) begin
        if (m_ev[n] == 32'hFFFF_FFFF) hw[n] = 1'b1;
        m_ev[n] = m_ev[n] + 1;
      end
      if (we && wa == 12'(32'h420 + n * 16)) m_ctl[n] = wd[31:0];
      if (we && wa == 12'(32'h423 + n * 16)) m_flt[n] = wd[31:0];
      if (we && wa == 12'(32'h424 + n * 16)) m_typ[n] = wd[2:0];
    end
    inc = m_gen && m_cen[31];
    if (zc) m_cyc = 0;
    else if (we && wa == 12'h40A) m_cyc = wd;
    else if (inc) begin
      if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) hw[31] = 1'b1;
      m_cyc = m_cyc + 1;
    end
    if (we && wa == 12'h409) m_cycctl = wd[31:0];
    sel = wd[31:0] & m_valid;
    if (we) begin
      if (wa == 12'h403) m_cen = m_cen & ~sel;
      if (wa == 12'h404) m_cen = m_cen | sel;
      if (wa == 12'h405) m_ien = m_ien & ~sel;
      if (wa == 12'h406) m_ien = m_ien | sel;
      if (wa == 12'h407) m_ovf = m_ovf & ~sel;
      if (wa == 12'h408) m_ovf = m_ovf | sel;
      if (wa == 12'h400) m_gen = wd[0];
    end
    m_ovf = m_ovf | hw;
  endtask

  // one clock: drive at the falling edge, compare, then advance the model
  task automatic step(input bit we, input logic [11:0] wa, input logic [63:0] wd,
                      input logic [11:0] ra, input logic [7:0] ev);
    logic [63:0] exp_rd;
    bit exp_irq;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; evt_pulse = ev;
    #1;
    exp_rd  = model_read(ra);
    exp_irq = |(m_ovf & m_ien);
    vectors++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s rd_addr=%h rd_data=%h expected %h irq=%b expected %b",
               cur_req, ra, rd_data, exp_rd, irq, exp_irq);
    end
    model_update(we, wa, wd, ev);
  endtask

  task automatic tick(input logic [7:0] ev);
    step(1'b0, 12'h000, 64'd0, sweep_addr(rp), ev);
    rp++;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [7:0] ev);
    step(1'b1, a, d, sweep_addr(rp), ev);
    rp++;
  endtask

  task automatic wr_rd(input logic [11:0] a, input logic [63:0] d, input logic [11:0] ra,
                       input logic [7:0] ev);
    step(1'b1, a, d, ra, ev);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL %s watchdog expired: run not complete, expected completion", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NE; n++) begin
      m_ev[n] = '0; m_ctl[n] = '0; m_flt[n] = '0; m_typ[n] = '0;
    end
    m_cyc = '0; m_cycctl = '0; m_cen = '0; m_ien = '0; m_ovf = '0; m_gen = 0;
    m_valid = 32'h8000_0000;
    for (int n = 0; n < NE; n++) m_valid[n] = 1'b1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values across every index
    cur_req = "R1";
    for (int i = 0; i < 45; i++) tick(8'h00);

    // R11: stored-only registers, R5 type assignment
    cur_req = "R11";
    for (int n = 0; n < NE; n++) begin
      wr(12'(32'h420 + n * 16), {$urandom, $urandom}, 8'h00);
      wr(12'(32'h423 + n * 16), {$urandom, $urandom}, 8'h00);
      wr(12'(32'h424 + n * 16), 64'(((n * 3) % 8) | 32'hF8), 8'h00);
    end
    wr(12'h409, 64'hDEAD_BEEF_1234_5678, 8'h00);
    for (int i = 0; i < 45; i++) tick(8'h00);

    // R4: set all mask bits, only implemented ones stick; clear one
    cur_req = "R4";
    wr_rd(12'h404, 64'hFFFF_FFFF_FFFF_FFFF, 12'h404, 8'h00);
    tick(8'h00);
    wr_rd(12'h403, 64'h10, 12'h403, 8'h00);
    step(1'b0, 12'h000, 64'd0, 12'h404, 8'h00);

    // R2: global enable, R5 counting with random pulses
    cur_req = "R2";
    wr_rd(12'h400, 64'h1, 12'h400, 8'h00);
    cur_req = "R5";
    for (int i = 0; i < 150; i++) tick(8'($urandom));
    cur_req = "R4";
    wr(12'h403, 64'h8000_0005, 8'hFF);
    for (int i = 0; i < 40; i++) tick(8'($urandom));

    // R2: global disable freezes everything
    cur_req = "R2";
    wr(12'h400, 64'h0, 8'hFF);
    for (int i = 0; i < 45; i++) tick(8'hFF);
    wr(12'h400, 64'h1, 8'h00);
    wr(12'h404, 64'hFFFF_FFFF, 8'h00);

    // R7: load beats increment on counter 1 (group 3)
    cur_req = "R7";
    wr_rd(12'h431, 64'h1234, 12'h431, 8'hFF);
    step(1'b0, 12'h000, 64'd0, 12'h431, 8'hFF);
    step(1'b0, 12'h000, 64'd0, 12'h431, 8'h00);

    // R8 / R10: counter 2 wraps and interrupts
    cur_req = "R8";
    wr(12'h406, 64'h4, 8'h00);
    wr(12'h441, 64'hFFFF_FFFD, 8'h00);
    for (int i = 0; i < 5; i++) step(1'b0, 12'h000, 64'd0, 12'h408, 8'hFF);
    cur_req = "R10";
    wr_rd(12'h407, 64'h4, 12'h408, 8'h00);
    step(1'b0, 12'h000, 64'd0, 12'h408, 8'h00);

    // R9: wrap on counter 3 in the same cycle as its flag clear
    cur_req = "R9";
    wr(12'h406, 64'h8, 8'h00);
    wr(12'h451, 64'hFFFF_FFFF, 8'h00);
    wr_rd(12'h407, 64'h8, 12'h408, 8'hFF);
    for (int i = 0; i < 3; i++) step(1'b0, 12'h000, 64'd0, 12'h408, 8'h00);
    wr_rd(12'h407, 64'hFFFF_FFFF, 12'h408, 8'h00);

    // R6 / R8: cycle counter wrap sets bit 31
    cur_req = "R6";
    wr(12'h406, 64'h8000_0000, 8'h00);
    wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFD, 8'h00);
    for (int i = 0; i < 5; i++) step(1'b0, 12'h000, 64'd0, (i % 2) ? 12'h408 : 12'h40A, 8'h00);
    wr(12'h407, 64'hFFFF_FFFF, 8'h00);

    // R3: zeroing writes while pulses are active
    cur_req = "R3";
    for (int i = 0; i < 20; i++) tick(8'hFF);
    wr_rd(12'h400, 64'h7, 12'h421, 8'hFF);
    for (int i = 0; i < 10; i++) tick(8'hFF);
    wr_rd(12'h400, 64'h3, 12'h40A, 8'hFF);
    step(1'b0, 12'h000, 64'd0, 12'h40A, 8'hFF);
    wr_rd(12'h400, 64'h5, 12'h40A, 8'hFF);
    for (int i = 0; i < 45; i++) tick(8'($urandom));

    // R12: unmapped writes change nothing, unmapped reads are zero
    cur_req = "R12";
    wr(12'h401, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    wr(12'h422, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    wr(12'h4A1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    wr(12'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    for (int i = 0; i < 45; i++) tick(8'h00);

    // R5: random mix of writes and pulses
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) begin
        logic [11:0] a;
        logic [63:0] d;
        a = sweep_addr($urandom % 45);
        d = {$urandom, $urandom};
        if (a == 12'h400) d = {61'd0, d[2:1] == 2'b11 ? 2'b00 : d[2:1], 1'b1};
        wr(a, d, 8'($urandom));
      end else begin
        tick(8'($urandom));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule